// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block is the receive front end of an I2C target device. It watches the serial clock and data lines at all times and finds the START and STOP conditions on them. After each START it shifts in the address phase and compares it with the device's own address. The own address is configured as either a 7-bit or a 10-bit value. When the address matches, the block pulls SDA low for the acknowledge bit, reports the match and the transfer direction, and then delivers the bytes that the controller writes.

When the address does not match, the block goes quiet. It ignores the bus until a STOP appears. A repeated START begins a new address phase at once. SDA is only ever pulled low and is never driven high. The caller turns `sda_oe` into an open-drain pull-down on the pad. The register file behind the device is not part of this block, and neither is the data returned on reads.

Top module: `i2c_addr_matcher`

## Requirements
- R1: A fall of SDA while SCL is high is a START. A rise of SDA while SCL is high is a STOP. After reset, and after every STOP, the block waits for a START before it takes any bits. Bits are sampled on SCL rising edges, most significant bit first.
- R2: In 7-bit mode (`ten_bit_mode`=0), the first byte after a START matches when its bits 7:1 equal `own_addr[6:0]`. Bit 0 of that byte gives the direction, with 1 meaning read. On a match, `addr_match` pulses high for one clock, `rw_dir` takes the direction bit, and the byte is acknowledged.
- R3: An acknowledge is given by setting `sda_oe` (1 = pull SDA low) at the SCL fall that follows the eighth bit. It is released at the SCL fall that follows the ninth clock. `sda_oe` changes only while SCL is low.
- R4: When an address byte is rejected, no acknowledge is given. Until the next STOP, no later byte is acknowledged or reported, even one equal to the own address.
- R5: In 10-bit mode, a first byte of the form 11110, then `own_addr[9:8]`, then 0 is acknowledged without a match pulse. A following second byte equal to `own_addr[7:0]` is acknowledged, pulses `addr_match`, and sets `rw_dir` to 0.
- R6: In 10-bit mode, a first byte with a different prefix or different upper bits gets no acknowledge. A second byte that differs from `own_addr[7:0]` also gets no acknowledge. Either case leads into the ignore state of R4.
- R7: In 10-bit mode, a first byte of 11110, then `own_addr[9:8]`, then 1 is acknowledged, with `addr_match` pulsed and `rw_dir`=1, only when a full 10-bit write match has occurred since the last STOP. Otherwise it is not acknowledged.
- R8: After a match with direction write, every following byte is presented on `rx_data`, with a one-clock `rx_valid` pulse, and is acknowledged.
- R9: A START seen in the middle of a transfer restarts address reception at once, without waiting for a STOP.
- R10: After a match with direction read, the block never pulls SDA low on the bytes that follow.
- R11: In 7-bit mode, a byte that begins with 11110 is compared as an ordinary 7-bit address. It never opens a 10-bit phase.
- R12: While reset is high, and right after it, `sda_oe`, `addr_match` and `rx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| own_addr | input | 10 | Own address; bits 6:0 are used in 7-bit mode |
| ten_bit_mode | input | 1 | 1 selects 10-bit own address |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_match | output | 1 | One-clock pulse on a full address match |
| rw_dir | output | 1 | Direction of the last matched transfer, 1 = read |
| rx_data | output | 8 | Last byte written by the controller |
| rx_valid | output | 1 | One-clock pulse when rx_data is new |

## Verification
The bench aims at the ignore state. After a rejected address it sends a byte equal to the own address. A design that wakes up early would acknowledge that byte, or report it. The 10-bit paths are each tested on their own: a wrong upper pair, a wrong low byte, and a read prefix sent without an earlier selection. A design that treated the prefix byte as a full match, or kept its selection across a STOP, would acknowledge where it should not.

Repeated START is tested in two ways. It is used to turn a write into a read, and it is used to leave a data phase. A design that waited for STOP would stay deaf or keep collecting data. In 7-bit mode the bench also uses an own address that begins with 11110. This exposes a design that opens a 10-bit phase regardless of the configured mode.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    localparam int BYTE_W     = 8;
    localparam int OWN_W      = 10;
    localparam int SHORT_W    = 7;
    localparam int BITCNT_W   = 4;
    localparam logic [4:0] TEN_PREFIX = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_WRITE,
        ST_READ,
        ST_DEAF
    } am_state_e;

    typedef struct packed {
        logic      hit;
        logic      ack;
        logic      dir;
        logic      sel10;
        am_state_e next;
    } am_decision_t;

    function automatic am_decision_t judge_first(
        input logic [BYTE_W-1:0] b,
        input logic              ten,
        input logic [OWN_W-1:0]  own,
        input logic              ten_sel
    );
        am_decision_t d;
        d.hit   = 1'b0;
        d.ack   = 1'b0;
        d.dir   = b[0];
        d.sel10 = ten_sel;
        d.next  = ST_DEAF;
        if (!ten) begin
            if (b[BYTE_W-1:1] == own[SHORT_W-1:0]) begin
                d.hit  = 1'b1;
                d.ack  = 1'b1;
                d.next = b[0] ? ST_READ : ST_WRITE;
            end
        end else if (b[7:3] == TEN_PREFIX && b[2:1] == own[OWN_W-1:BYTE_W]) begin
            if (!b[0]) begin
                d.ack  = 1'b1;
                d.next = ST_ADDR_LO;
            end else if (ten_sel) begin
                d.hit  = 1'b1;
                d.ack  = 1'b1;
                d.next = ST_READ;
            end
        end
        if (!d.ack) d.sel10 = 1'b0;
        return d;
    endfunction

    function automatic am_decision_t judge_second(
        input logic [BYTE_W-1:0] b,
        input logic [OWN_W-1:0]  own
    );
        am_decision_t d;
        d.hit   = (b == own[BYTE_W-1:0]);
        d.ack   = d.hit;
        d.dir   = 1'b0;
        d.sel10 = d.hit;
        d.next  = d.hit ? ST_WRITE : ST_DEAF;
        return d;
    endfunction

endpackage

// File: rtl/i2c_am_line_sync.sv
module i2c_am_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic              scl_prev, sda_prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff[g] <= 1'b1;
                    sda_ff[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_ff[g] <= scl_in;
                    sda_ff[g] <= sda_in;
                end else begin
                    scl_ff[g] <= scl_ff[(g == 0) ? 0 : g-1];
                    sda_ff[g] <= sda_ff[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_ff[STAGES-1];
            sda_prev <= sda_ff[STAGES-1];
        end
    end

    assign scl_q     = scl_ff[STAGES-1];
    assign sda_q     = sda_ff[STAGES-1];
    assign scl_rise  = scl_q & ~scl_prev;
    assign scl_fall  = ~scl_q & scl_prev;
    assign start_det = scl_q & scl_prev & sda_prev & ~sda_q;
    assign stop_det  = scl_q & scl_prev & ~sda_prev & sda_q;

    p_no_start_and_stop_r1: assert property (@(posedge clk) disable iff (rst)
        !(start_det && stop_det));

endmodule

// File: rtl/i2c_am_shifter.sv
module i2c_am_shifter
    import i2c_am_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              scl_rise,
    input  logic              sda_bit,
    output logic [BYTE_W-1:0] byte_q,
    output logic              byte_done,
    output logic              ack_slot
);
    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W - 1);
    localparam logic [BITCNT_W-1:0] ACK_POS  = BITCNT_W'(BYTE_W);

    logic [BITCNT_W-1:0] bit_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt   <= '0;
            byte_q    <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (restart) begin
                bit_cnt <= '0;
            end else if (scl_rise) begin
                if (bit_cnt == ACK_POS) begin
                    bit_cnt <= '0;
                end else begin
                    byte_q  <= {byte_q[BYTE_W-2:0], sda_bit};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == LAST_BIT) byte_done <= 1'b1;
                end
            end
        end
    end

    assign ack_slot = (bit_cnt == ACK_POS);

    p_bitcnt_range_r1: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= ACK_POS);
    p_done_then_slot_r3: assert property (@(posedge clk) disable iff (rst)
        byte_done |-> ack_slot);

endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
    import i2c_am_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [OWN_W-1:0]  own_addr,
    input  logic              ten_bit_mode,
    output logic              sda_oe,
    output logic              addr_match,
    output logic              rw_dir,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid
);
    logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] cur_byte;
    logic byte_done, ack_slot;
    am_state_e state;
    logic ack_pending, ten_sel;
    am_decision_t dec_first, dec_second;

    i2c_am_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_i), .sda_in(sda_i),
        .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_am_shifter u_shift (
        .clk(clk), .rst(rst), .restart(start_det | stop_det),
        .scl_rise(scl_rise), .sda_bit(sda_q),
        .byte_q(cur_byte), .byte_done(byte_done), .ack_slot(ack_slot)
    );

    always_comb begin
        dec_first  = judge_first(cur_byte, ten_bit_mode, own_addr, ten_sel);
        dec_second = judge_second(cur_byte, own_addr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            ack_pending <= 1'b0;
            ten_sel     <= 1'b0;
            sda_oe      <= 1'b0;
            addr_match  <= 1'b0;
            rw_dir      <= 1'b0;
            rx_data     <= '0;
            rx_valid    <= 1'b0;
        end else begin
            addr_match <= 1'b0;
            rx_valid   <= 1'b0;
            if (stop_det) begin
                state       <= ST_IDLE;
                ten_sel     <= 1'b0;
                ack_pending <= 1'b0;
            end else if (start_det) begin
                state       <= ST_ADDR_HI;
                ack_pending <= 1'b0;
            end else if (byte_done) begin
                case (state)
                    ST_ADDR_HI: begin
                        state       <= dec_first.next;
                        ack_pending <= dec_first.ack;
                        addr_match  <= dec_first.hit;
                        ten_sel     <= dec_first.sel10;
                        if (dec_first.hit) rw_dir <= dec_first.dir;
                    end
                    ST_ADDR_LO: begin
                        state       <= dec_second.next;
                        ack_pending <= dec_second.ack;
                        addr_match  <= dec_second.hit;
                        ten_sel     <= dec_second.sel10;
                        if (dec_second.hit) rw_dir <= dec_second.dir;
                    end
                    ST_WRITE: begin
                        rx_data     <= cur_byte;
                        rx_valid    <= 1'b1;
                        ack_pending <= 1'b1;
                    end
                    default: ;
                endcase
            end else if (scl_fall) begin
                if (ack_pending && ack_slot) begin
                    sda_oe      <= 1'b1;
                    ack_pending <= 1'b0;
                end else if (!ack_slot) begin
                    sda_oe <= 1'b0;
                end
            end
        end
    end

    p_oe_moves_scl_low_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_q);
    p_match_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        addr_match |=> !addr_match);
    p_deaf_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DEAF) |-> (!sda_oe && !rx_valid && !addr_match));
    p_restart_addr_r9: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (state == ST_ADDR_HI));
    p_read_no_ack_r10: assert property (@(posedge clk) disable iff (rst)
        (byte_done && state == ST_READ) |=> !ack_pending);
    p_rx_in_write_r8: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (state == ST_WRITE));

endmodule

// File: tb/i2c_addr_matcher_bench.sv
`timescale 1ns/1ps
module i2c_addr_matcher_bench;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [9:0] own_addr = 10'h03A;
    logic       ten_bit_mode = 1'b0;
    logic       sda_oe, addr_match, rw_dir, rx_valid;
    logic [7:0] rx_data;
    logic       sda_line;

    int checks = 0;
    int failures = 0;
    int match_cnt = 0;
    int rx_cnt = 0;
    logic [7:0] rx_log [16];
    bit done = 0;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_addr_matcher u_i2c_addr_matcher (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .own_addr(own_addr), .ten_bit_mode(ten_bit_mode),
        .sda_oe(sda_oe), .addr_match(addr_match), .rw_dir(rw_dir),
        .rx_data(rx_data), .rx_valid(rx_valid)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (addr_match) match_cnt++;
            if (rx_valid) begin
                if (rx_cnt < 16) rx_log[rx_cnt] = rx_data;
                rx_cnt++;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_q(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        sda_m = 1'b0; wait_q(1);
        scl_m = 1'b0; wait_q(1);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        sda_m = 1'b1; wait_q(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_q(1);
            scl_m = 1'b1; wait_q(2);
            scl_m = 1'b0; wait_q(1);
        end
        sda_m = 1'b1; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        acked = !sda_line;
        wait_q(1);
        scl_m = 1'b0; wait_q(1);
    endtask

    task automatic t_reset;
        check(sda_oe == 1'b0, "R12 sda_oe after reset", sda_oe, 0);
        check(addr_match == 1'b0 && rx_valid == 1'b0, "R12 pulses after reset",
              {addr_match, rx_valid}, 0);
    endtask

    task automatic t_seven_write;
        bit a; int m0, r0;
        own_addr = 10'h03A; ten_bit_mode = 1'b0;
        m0 = match_cnt; r0 = rx_cnt;
        send_byte(8'h74, a);
        check(a == 0, "R1 no bits taken before START", a, 0);
        bus_start;
        send_byte(8'h74, a);
        check(a == 1, "R2 7-bit match ack", a, 1);
        check(match_cnt == m0 + 1 && rw_dir == 0, "R2 match pulse and write dir",
              match_cnt - m0, 1);
        send_byte(8'hA5, a);
        check(a == 1, "R8 data ack", a, 1);
        send_byte(8'h5C, a);
        check(a == 1 && rx_cnt == r0 + 2, "R8 data count", rx_cnt - r0, 2);
        check(rx_log[r0] == 8'hA5 && rx_log[r0+1] == 8'h5C, "R8 data values",
              {rx_log[r0], rx_log[r0+1]}, 16'hA55C);
        bus_stop;
    endtask

    task automatic t_ack_timing;
        bit a;
        bus_start;
        for (int i = 7; i >= 0; i--) begin
            sda_m = 8'h74 >> i; wait_q(1);
            scl_m = 1'b1; wait_q(2);
            scl_m = 1'b0; wait_q(1);
        end
        sda_m = 1'b1;
        check(sda_oe == 1, "R3 ack driven in ninth low phase", sda_oe, 1);
        wait_q(1); scl_m = 1'b1; wait_q(2);
        check(sda_oe == 1, "R3 ack held through ninth high", sda_oe, 1);
        scl_m = 1'b0; wait_q(1);
        check(sda_oe == 0, "R3 ack released after ninth fall", sda_oe, 0);
        a = 0;
        bus_stop;
    endtask

    task automatic t_mismatch_deaf;
        bit a; int m0, r0;
        m0 = match_cnt; r0 = rx_cnt;
        bus_start;
        send_byte(8'h76, a);
        check(a == 0, "R4 wrong address nack", a, 0);
        send_byte(8'h74, a);
        check(a == 0 && match_cnt == m0 && rx_cnt == r0, "R4 deaf to own address",
              match_cnt - m0, 0);
        bus_stop;
        bus_start;
        send_byte(8'h74, a);
        check(a == 1, "R4 listens again after STOP", a, 1);
        bus_stop;
    endtask

    task automatic t_repeated_start;
        bit a; int m0, r0;
        m0 = match_cnt;
        bus_start;
        send_byte(8'h76, a);
        bus_start;
        send_byte(8'h74, a);
        check(a == 1, "R9 repeated START leaves deaf state", a, 1);
        send_byte(8'h11, a);
        r0 = rx_cnt;
        bus_start;
        send_byte(8'h75, a);
        check(a == 1 && rw_dir == 1 && match_cnt == m0 + 2, "R9 restart to read",
              rw_dir, 1);
        send_byte(8'hFF, a);
        check(a == 0 && rx_cnt == r0, "R10 read bytes not acked", a, 0);
        send_byte(8'h00, a);
        check(a == 0, "R10 read release second byte", a, 0);
        bus_stop;
    endtask

    task automatic t_ten_write;
        bit a; int m0, r0;
        own_addr = 10'h2B7; ten_bit_mode = 1'b1;
        m0 = match_cnt; r0 = rx_cnt;
        bus_start;
        send_byte(8'hF4, a);
        check(a == 1 && match_cnt == m0, "R5 prefix acked without match", a, 1);
        send_byte(8'hB7, a);
        check(a == 1 && match_cnt == m0 + 1 && rw_dir == 0, "R5 second byte match",
              match_cnt - m0, 1);
        send_byte(8'h3C, a);
        check(a == 1 && rx_log[r0] == 8'h3C, "R8 10-bit data", rx_log[r0], 8'h3C);
        bus_start;
        send_byte(8'hF5, a);
        check(a == 1 && rw_dir == 1 && match_cnt == m0 + 2, "R7 10-bit read after select",
              rw_dir, 1);
        bus_stop;
    endtask

    task automatic t_ten_bad;
        bit a; int m0;
        m0 = match_cnt;
        bus_start;
        send_byte(8'hF2, a);
        check(a == 0, "R6 wrong upper bits nack", a, 0);
        send_byte(8'hB7, a);
        check(a == 0, "R6 deaf after upper mismatch", a, 0);
        bus_stop;
        bus_start;
        send_byte(8'hF4, a);
        send_byte(8'hB6, a);
        check(a == 0, "R6 wrong low byte nack", a, 0);
        send_byte(8'hB7, a);
        check(a == 0 && match_cnt == m0, "R6 deaf after low mismatch", a, 0);
        bus_stop;
        bus_start;
        send_byte(8'hF5, a);
        check(a == 0 && match_cnt == m0, "R7 read prefix without select nack", a, 0);
        bus_stop;
    endtask

    task automatic t_short_prefix;
        bit a; int r0;
        own_addr = 10'h07A; ten_bit_mode = 1'b0;
        r0 = rx_cnt;
        bus_start;
        send_byte(8'hF4, a);
        check(a == 1 && rw_dir == 0, "R11 11110 byte is plain 7-bit match", a, 1);
        send_byte(8'hB7, a);
        check(a == 1 && rx_cnt == r0 + 1 && rx_log[r0] == 8'hB7,
              "R11 next byte is data", rx_log[r0], 8'hB7);
        bus_stop;
    endtask

    initial begin
        repeat (20) @(negedge clk);
        t_reset;
        rst = 1'b0;
        repeat (10) @(negedge clk);
        t_reset;
        t_seven_write;
        t_ack_timing;
        t_mismatch_deaf;
        t_repeated_start;
        t_ten_write;
        t_ten_bad;
        t_short_prefix;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule